// File: doc/BRIEF.md
# Strobe-Framed Serial Bit Receiver

This block receives a serial bit stream from an external master that controls the framing. The master sends a serial clock, a data line and a start strobe. The strobe is high for exactly one serial clock period and marks the start of a frame. After each strobe the block collects a programmed number of NRZ bits, one per serial clock period. It passes each bit to a downstream bit-wide FIFO as a single-cycle write strobe with the data. After the last bit it ignores the data line until the next strobe arrives.

The serial inputs are not in the system clock domain. Each one passes through a two-flop synchronizer clocked by a system clock that runs at least four times the serial clock rate. The serial clock edges are then found on the synchronized copy. Three configuration inputs set the behaviour:

- the serial clock edge on which bits are taken;
- whether the first bit shares its period with the strobe or follows it;
- a 4-bit code that selects the frame length.

The FIFO reports when it is full. A bit that arrives while the FIFO is full is dropped and a sticky overflow flag is set.

Top module: `sbit_rx`

## Requirements
- R1: During reset and in the cycle after it is released, `wr_en`, `frame_done` and `overflow` are low.
- R2: With `cfg_rise`=0 a bit is taken on a falling edge of `sclk_in`; with `cfg_rise`=1 it is taken on a rising edge. The value taken is the one the data line holds just before that edge.
- R3: With `cfg_late`=0 the data bit present in the strobe period is the first bit of the frame.
- R4: With `cfg_late`=1 the data in the strobe period is discarded, and the first bit of the frame is taken in the next serial period.
- R5: The frame length code `cfg_len` maps as follows. Codes 0 to 10 give 4 to 14 bits (code + 4). Code 11 gives 16 bits, code 12 gives 24, code 13 gives 32, and codes 14 and 15 give 48.
- R6: Once a frame has taken its programmed number of bits, further serial periods without a strobe produce no writes.
- R7: `frame_done` pulses high for one system cycle, in the same cycle as the write of the frame's last bit.
- R8: A strobe that arrives before the current frame is complete abandons that frame without a `frame_done` pulse and starts a new frame with a count of zero.
- R9: A bit taken while `fifo_full` is high is not written, but it still counts toward the frame length. It sets `overflow`, which stays high until reset.
- R10: With `cfg_late`=0 a strobe may come in the period right after the last bit of the previous frame, and both frames are received complete.
- R11: Each bit taken produces exactly one single-cycle `wr_en` pulse with `wr_bit` equal to the bit, and bits are written in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_in | input | 1 | Serial clock from the master |
| strobe_in | input | 1 | Frame-start strobe, one serial period long |
| sdata_in | input | 1 | Serial NRZ data |
| cfg_rise | input | 1 | 0: take bits on the falling edge, 1: on the rising edge |
| cfg_late | input | 1 | 0: first bit in the strobe period, 1: first bit in the period after |
| cfg_len | input | 4 | Frame length code |
| fifo_full | input | 1 | Downstream FIFO cannot accept a bit |
| wr_en | output | 1 | FIFO write strobe |
| wr_bit | output | 1 | Bit to write |
| frame_done | output | 1 | Last bit of a frame taken |
| overflow | output | 1 | Sticky: a bit was dropped on a full FIFO |

## Verification
The assertions assume three things about the inputs:

- Serial clock edges are at least four system cycles apart, so write and done pulses can never come in back-to-back cycles.
- `cfg_len` is held while a frame is in progress, so the bit count never passes the decoded length.
- Data and strobe are stable around the sampling edge.

The stimulus keeps to these. It uses a half period of six system cycles, changes data and strobe two system cycles after the driving edge, and changes configuration only between frames while the receiver is idle.

// File: rtl/sbit_rx.sv
module sbit_rx #(
  parameter int LEN_W = 4,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_in,
  input  logic             strobe_in,
  input  logic             sdata_in,
  input  logic             cfg_rise,
  input  logic             cfg_late,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             fifo_full,
  output logic             wr_en,
  output logic             wr_bit,
  output logic             frame_done,
  output logic             overflow
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] frame_bits(input logic [LEN_W-1:0] code);
    case (code)
      LEN_W'(11): return CNT_W'(16);
      LEN_W'(12): return CNT_W'(24);
      LEN_W'(13): return CNT_W'(32);
      LEN_W'(14), LEN_W'(15): return CNT_W'(48);
      default:    return CNT_W'(code) + CNT_W'(4);
    endcase
  endfunction

  logic [1:0] sclk_sy, stb_sy, dat_sy;
  logic       sclk_q;
  logic       active;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      stb_sy  <= '0;
      dat_sy  <= '0;
      sclk_q  <= 1'b0;
    end else begin
      sclk_sy <= {sclk_sy[0], sclk_in};
      stb_sy  <= {stb_sy[0], strobe_in};
      dat_sy  <= {dat_sy[0], sdata_in};
      sclk_q  <= sclk_sy[1];
    end
  end

  wire sclk_s = sclk_sy[1];
  wire stb_s  = stb_sy[1];
  wire dat_s  = dat_sy[1];

  wire              sample   = cfg_rise ? (sclk_s & ~sclk_q) : (~sclk_s & sclk_q);
  wire [CNT_W-1:0]  len_bits = frame_bits(cfg_len);
  wire              take     = sample & (stb_s ? ~cfg_late : active);
  wire [CNT_W-1:0]  cnt_nxt  = cnt + ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      cnt        <= '0;
      wr_en      <= 1'b0;
      wr_bit     <= 1'b0;
      frame_done <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      wr_en      <= 1'b0;
      frame_done <= 1'b0;
      if (sample && stb_s) begin
        active <= 1'b1;
        cnt    <= cfg_late ? '0 : ONE;
      end else if (sample && active) begin
        cnt <= cnt_nxt;
        if (cnt_nxt >= len_bits) begin
          active     <= 1'b0;
          frame_done <= 1'b1;
        end
      end
      if (take) begin
        if (fifo_full) overflow <= 1'b1;
        else begin
          wr_en  <= 1'b1;
          wr_bit <= dat_s;
        end
      end
    end
  end

  // R9
  wr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !$past(fifo_full));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !active);

  // R11
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < len_bits));

endmodule

// File: tb/sbit_rx_bench.sv
module sbit_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_in = 1'b0, strobe_in = 1'b0, sdata_in = 1'b0;
  logic cfg_rise = 1'b0, cfg_late = 1'b0, fifo_full = 1'b0;
  logic [3:0] cfg_len = 4'd0;
  logic wr_en, wr_bit, frame_done, overflow;

  sbit_rx u_sbit_rx (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .strobe_in(strobe_in),
    .sdata_in(sdata_in), .cfg_rise(cfg_rise), .cfg_late(cfg_late),
    .cfg_len(cfg_len), .fifo_full(fifo_full), .wr_en(wr_en),
    .wr_bit(wr_bit), .frame_done(frame_done), .overflow(overflow));

  always #4 clk = ~clk;

  int nchk = 0, nbad = 0;
  int nwr = 0, ndone = 0, done_at = -1;
  logic rec [0:127];

  always @(negedge clk) if (rst_n) begin
    if (wr_en) begin
      if (nwr < 128) rec[nwr] = wr_bit;
      nwr = nwr + 1;
    end
    if (frame_done) begin
      ndone = ndone + 1;
      done_at = nwr;
    end
  end

  // {cfg_rise, cfg_late, cfg_len, pattern (bit i sent i-th)}
  localparam logic [53:0] VEC [16] = '{
    {1'b0, 1'b0, 4'd0,  48'h5},
    {1'b1, 1'b0, 4'd1,  48'h1A},
    {1'b0, 1'b1, 4'd2,  48'h2D},
    {1'b1, 1'b1, 4'd3,  48'h96},
    {1'b0, 1'b0, 4'd4,  48'hA5},
    {1'b1, 1'b0, 4'd5,  48'h13B},
    {1'b0, 1'b1, 4'd6,  48'h2C9},
    {1'b1, 1'b1, 4'd7,  48'h5E1},
    {1'b0, 1'b0, 4'd8,  48'hB47},
    {1'b1, 1'b1, 4'd9,  48'h1D2C},
    {1'b0, 1'b1, 4'd10, 48'h3A5C},
    {1'b1, 1'b0, 4'd11, 48'hC3A5},
    {1'b0, 1'b1, 4'd12, 48'hA5F00F},
    {1'b1, 1'b0, 4'd13, 48'hDEADBEEF},
    {1'b0, 1'b0, 4'd14, 48'h123456789ABC},
    {1'b1, 1'b1, 4'd15, 48'hFEDCBA987654}
  };

  function automatic int exp_len(input logic [3:0] c);
    if (c <= 4'd10) return int'(c) + 4;
    case (c)
      4'd11: return 16;
      4'd12: return 24;
      4'd13: return 32;
      default: return 48;
    endcase
  endfunction

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    nchk = nchk + 1;
    if (act != exp) begin
      nbad = nbad + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one serial period: drive edge, data changes 2 cycles later, sample edge after 6
  task automatic period(input logic stb, input logic d);
    sclk_in = ~cfg_rise;
    waitc(2);
    strobe_in = stb;
    sdata_in  = d;
    waitc(4);
    sclk_in = cfg_rise;
    waitc(6);
  endtask

  task automatic setup(input logic r, input logic l, input logic [3:0] c);
    cfg_rise = r; cfg_late = l; cfg_len = c;
    strobe_in = 1'b0;
    sclk_in = r;
    waitc(10);
    nwr = 0; ndone = 0; done_at = -1;
  endtask

  task automatic frame(input logic [47:0] pat, input int len);
    if (cfg_late) begin
      period(1'b1, ~pat[0]);
      for (int i = 0; i < len; i++) period(1'b0, pat[i]);
    end else begin
      period(1'b1, pat[0]);
      for (int i = 1; i < len; i++) period(1'b0, pat[i]);
    end
  endtask

  task automatic bits_check(input string req, input logic [47:0] pat, input int len, input int base);
    int bad = 0;
    for (int i = 0; i < len; i++)
      if (base + i < 128 && rec[base + i] !== pat[i]) bad = bad + 1;
    check(req, bad, 0);
  endtask

  initial begin
    int to = 0;
    while (to < 190000) begin @(posedge clk); to = to + 1; end
    nbad = nbad + 1;
    nchk = nchk + 1;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    logic [47:0] pa, pb;
    waitc(5);
    check("R1 wr_en in reset", int'(wr_en), 0);
    check("R1 overflow in reset", int'(overflow), 0);
    rst_n = 1'b1;
    waitc(1);
    check("R1 frame_done after reset", int'(frame_done), 0);
    check("R1 overflow after reset", int'(overflow), 0);

    // table walk: R2 R3 R4 R5 R6 R7 R11
    for (int v = 0; v < 16; v++) begin
      logic [53:0] e = VEC[v];
      int len = exp_len(e[51:48]);
      setup(e[53], e[52], e[51:48]);
      frame(e[47:0], len);
      period(1'b0, 1'b1); period(1'b0, 1'b0); period(1'b0, 1'b1);
      waitc(12);
      check(e[52] ? "R5/R6 count late" : "R5/R6 count", nwr, len);
      bits_check(e[52] ? (e[53] ? "R4/R2 rise bits" : "R4/R2 fall bits")
                       : (e[53] ? "R3/R2 rise bits" : "R3/R2 fall bits"),
                 e[47:0], len, 0);
      check("R7 one done", ndone, 1);
      check("R7 done with last write", done_at, len);
    end

    // R10 back-to-back frames, no idle period
    setup(1'b0, 1'b0, 4'd0);
    pa = 48'hD; pb = 48'h2;
    frame(pa, 4);
    frame(pb, 4);
    waitc(12);
    check("R10 writes", nwr, 8);
    check("R10 dones", ndone, 2);
    bits_check("R10 first bits", pa, 4, 0);
    bits_check("R10 second bits", pb, 4, 4);

    // R8 abort mid-frame
    setup(1'b1, 1'b1, 4'd4);
    pa = 48'h6B;
    period(1'b1, 1'b0);
    period(1'b0, 1'b1); period(1'b0, 1'b1); period(1'b0, 1'b0);
    frame(pa, 8);
    waitc(12);
    check("R8 writes", nwr, 11);
    check("R8 single done", ndone, 1);
    check("R8 done at end", done_at, 11);
    bits_check("R8 restarted bits", pa, 8, 3);

    // R9 overflow on full FIFO
    setup(1'b0, 1'b0, 4'd0);
    fifo_full = 1'b1;
    frame(48'hF, 4);
    waitc(12);
    check("R9 no writes when full", nwr, 0);
    check("R9 overflow set", int'(overflow), 1);
    check("R9 frame still completes", ndone, 1);
    fifo_full = 1'b0;
    setup(1'b0, 1'b0, 4'd0);
    frame(48'h9, 4);
    waitc(12);
    check("R9 writes resume", nwr, 4);
    check("R9 overflow sticky", int'(overflow), 1);
    rst_n = 1'b0;
    waitc(3);
    rst_n = 1'b1;
    waitc(1);
    check("R1 overflow cleared by reset", int'(overflow), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule